// File: doc/BRIEF.md
# Cascaded FIFO Tapped Delay Line

This block turns one stream of complex samples into eight parallel streams, each a fixed number of samples older than the one before it. It is a chain of identical first-in first-out stages. Each stage keeps one block of `DEPTH` samples. It sends a sample onward only once it is full and a new sample comes in. Each stage therefore acts as an exact `DEPTH`-sample delay, counted in accepted samples and not in clock cycles. Every stage output is a tap. A polyphase filter branch array downstream reads the taps as one row per accepted input.

The stages have different pipeline depths. Short skew pipes pad the stage outputs so that all taps of one row leave on the same clock edge. A common row strobe marks each row. A per-tap valid flag shows which taps already carry real data.

Top module: `tdl_cascade`

## Requirements
- R1: For the n-th accepted input sample (n counted from 0 after reset), tap k (k = 0..STAGES-1) carries the sample accepted at index n - DEPTH*(k+1). Tap k sits at bits [16k+15:16k] of `tap_i` and of `tap_q`.
- R2: The I and Q parts travel together as one word. The Q value on a tap always belongs to the same input sample as the I value on that tap.
- R3: `tap_vld[k]` is high on a row if and only if that row's input index n satisfies n >= DEPTH*(k+1). All taps are valid only from input index STAGES*DEPTH onward.
- R4: `out_vld` is high for exactly one cycle per accepted input. That cycle comes STAGES clock edges after the edge that captured the input.
- R5: A cycle with `in_vld` low writes nothing, moves no sample and produces no row. The delay is counted in accepted samples only.
- R6: A synchronous active-high reset clears all pointers and fill counters. On the edge after reset, `out_vld` and all `tap_vld` bits are low. Filling then restarts from empty, and no sample from before the reset ever reaches a tap.
- R7: Taps become valid in order: `tap_vld[k]` high implies `tap_vld[k-1]` high.
- R8: No `tap_vld` bit is high in a cycle where `out_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input sample strobe |
| in_i | input | 16 | Input in-phase part, signed |
| in_q | input | 16 | Input quadrature part, signed |
| out_vld | output | 1 | Row strobe, one per accepted input |
| tap_vld | output | STAGES | Per-tap valid flags for the current row |
| tap_i | output | 16*STAGES | Tap in-phase parts, tap k at bits [16k+15:16k] |
| tap_q | output | 16*STAGES | Tap quadrature parts, tap k at bits [16k+15:16k] |

## Verification
Each row is due exactly STAGES clock edges after the edge that captured its input, whatever the idle cycles around it. The driver stamps every expected row with the cycle count at which it must appear. The monitor samples at the falling edge and requires `out_vld` in exactly the stamped cycle and in no other cycle. The expected tap values and valid mask come from a history of accepted samples kept by the bench, so idle gaps and a reset in the middle of a run test that the delay counts samples and not cycles.

// File: rtl/tdl_pkg.sv
package tdl_pkg;
  localparam int SAMPLE_W = 16;

  typedef struct packed {
    logic signed [SAMPLE_W-1:0] i;
    logic signed [SAMPLE_W-1:0] q;
  } sample_t;
endpackage

// File: rtl/tdl_fifo_stage.sv
module tdl_fifo_stage
  import tdl_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    in_vld,
  input  sample_t in_dat,
  output logic    out_vld,
  output sample_t out_dat
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  sample_t       mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] fill;
  logic          full;
  logic          rd_en;

  assign full  = (fill == FULL_CNT);
  assign rd_en = in_vld & full;

  // storage array: no reset so that it maps onto block RAM
  always_ff @(posedge clk) begin
    if (in_vld) mem[wr_ptr] <= in_dat;
  end

  // registered read port, read-before-write on the shared address
  always_ff @(posedge clk) begin
    if (rd_en) out_dat <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      fill    <= '0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= rd_en;
      if (in_vld) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (rd_en)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (in_vld && !full) fill <= fill + 1'b1;
    end
  end
endmodule

// File: rtl/tdl_skew.sv
module tdl_skew
  import tdl_pkg::*;
#(
  parameter int LAT = 1
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    in_vld,
  input  sample_t in_dat,
  output logic    out_vld,
  output sample_t out_dat
);
  logic    v [LAT];
  sample_t d [LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < LAT; j++) v[j] <= 1'b0;
    end else begin
      v[0] <= in_vld;
      for (int j = 1; j < LAT; j++) v[j] <= v[j-1];
    end
  end

  always_ff @(posedge clk) begin
    d[0] <= in_dat;
    for (int j = 1; j < LAT; j++) d[j] <= d[j-1];
  end

  assign out_vld = v[LAT-1];
  assign out_dat = d[LAT-1];
endmodule

// File: rtl/tdl_cascade.sv
module tdl_cascade
  import tdl_pkg::*;
#(
  parameter int STAGES = 8,
  parameter int DEPTH  = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_vld,
  input  logic signed [SAMPLE_W-1:0]   in_i,
  input  logic signed [SAMPLE_W-1:0]   in_q,
  output logic                         out_vld,
  output logic [STAGES-1:0]            tap_vld,
  output logic [STAGES*SAMPLE_W-1:0]   tap_i,
  output logic [STAGES*SAMPLE_W-1:0]   tap_q
);
  sample_t st_din  [STAGES];
  sample_t st_dout [STAGES];
  logic    st_vin  [STAGES];
  logic    st_vout [STAGES];
  sample_t al_dat  [STAGES];
  logic    al_vld  [STAGES];
  logic [STAGES-1:0] row_pipe;

  assign st_din[0] = '{i: in_i, q: in_q};
  assign st_vin[0] = in_vld;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k > 0) begin : g_link
      assign st_din[k] = st_dout[k-1];
      assign st_vin[k] = st_vout[k-1];
    end

    tdl_fifo_stage #(.DEPTH(DEPTH)) u_stage (
      .clk     (clk),
      .rst     (rst),
      .in_vld  (st_vin[k]),
      .in_dat  (st_din[k]),
      .out_vld (st_vout[k]),
      .out_dat (st_dout[k])
    );

    if (k < STAGES - 1) begin : g_pad
      tdl_skew #(.LAT(STAGES - 1 - k)) u_skew (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (st_vout[k]),
        .in_dat  (st_dout[k]),
        .out_vld (al_vld[k]),
        .out_dat (al_dat[k])
      );
    end else begin : g_last
      assign al_vld[k] = st_vout[k];
      assign al_dat[k] = st_dout[k];
    end

    assign tap_vld[k]                     = al_vld[k];
    assign tap_i[k*SAMPLE_W +: SAMPLE_W]  = al_dat[k].i;
    assign tap_q[k*SAMPLE_W +: SAMPLE_W]  = al_dat[k].q;
  end

  always_ff @(posedge clk) begin
    if (rst) row_pipe <= '0;
    else     row_pipe <= {row_pipe[STAGES-2:0], in_vld};
  end

  assign out_vld = row_pipe[STAGES-1];
endmodule

// File: rtl/tdl_cascade_chk.sv
module tdl_cascade_chk #(
  parameter int STAGES = 8,
  parameter int DEPTH  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_vld,
  input logic              out_vld,
  input logic [STAGES-1:0] tap_vld
);
  logic [STAGES-1:0] vld_hist;
  logic [31:0]       acc_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_hist <= '0;
      acc_cnt  <= '0;
    end else begin
      vld_hist <= {vld_hist[STAGES-2:0], in_vld};
      if (in_vld && acc_cnt != 32'hFFFF_FFFF) acc_cnt <= acc_cnt + 1;
    end
  end

  // R4
  row_latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld == vld_hist[STAGES-1]);

  // R8
  tap_with_row_chk: assert property (@(posedge clk) disable iff (rst)
    (|tap_vld) |-> out_vld);

  // R6
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_vld && tap_vld == '0));

  for (genvar k = 0; k < STAGES; k++) begin : g_tap
    // R3
    tap_fill_chk: assert property (@(posedge clk) disable iff (rst)
      tap_vld[k] |-> (acc_cnt > 32'(DEPTH * (k + 1))));
    if (k > 0) begin : g_ord
      // R7
      tap_order_chk: assert property (@(posedge clk) disable iff (rst)
        tap_vld[k] |-> tap_vld[k-1]);
    end
  end
endmodule

bind tdl_cascade tdl_cascade_chk #(.STAGES(STAGES), .DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_vld  (in_vld),
  .out_vld (out_vld),
  .tap_vld (tap_vld)
);

// File: tb/tb_tdl_cascade.sv
module tb_tdl_cascade;
  localparam int STAGES = 8;
  localparam int DEPTH  = 32;
  localparam int SW     = 16;

  typedef struct {
    int                    stamp;
    logic [STAGES-1:0]     mask;
    logic [STAGES*SW-1:0]  ei;
    logic [STAGES*SW-1:0]  eq;
  } row_t;

  logic                      clk = 1'b0;
  logic                      rst = 1'b1;
  logic                      in_vld = 1'b0;
  logic signed [SW-1:0]      in_i = '0;
  logic signed [SW-1:0]      in_q = '0;
  logic                      out_vld;
  logic [STAGES-1:0]         tap_vld;
  logic [STAGES*SW-1:0]      tap_i;
  logic [STAGES*SW-1:0]      tap_q;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;
  logic [2*SW-1:0] hist [$];
  row_t            sb   [$];

  tdl_cascade #(.STAGES(STAGES), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_i(in_i), .in_q(in_q),
    .out_vld(out_vld), .tap_vld(tap_vld), .tap_i(tap_i), .tap_q(tap_q)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic send(input logic [SW-1:0] vi, input logic [SW-1:0] vq);
    row_t r;
    int n;
    @(negedge clk);
    in_vld = 1'b1; in_i = vi; in_q = vq;
    n = hist.size();
    r.stamp = cyc + STAGES;
    r.mask = '0; r.ei = '0; r.eq = '0;
    for (int k = 0; k < STAGES; k++) begin
      if (n >= DEPTH * (k + 1)) begin
        r.mask[k] = 1'b1;
        r.ei[k*SW +: SW] = hist[n - DEPTH*(k+1)][2*SW-1:SW];
        r.eq[k*SW +: SW] = hist[n - DEPTH*(k+1)][SW-1:0];
      end
    end
    hist.push_back({vi, vq});
    sb.push_back(r);
  endtask

  task automatic idle(input int cycles);
    for (int j = 0; j < cycles; j++) begin
      @(negedge clk);
      in_vld = 1'b0; in_i = 16'h5A5A; in_q = 16'hA5A5;
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: rows must appear exactly at their stamped cycle
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit due;
      due = (sb.size() > 0) && (sb[0].stamp == cyc);
      if (out_vld !== due)
        check(1'b0, due ? "R4" : "R5", "row strobe", 128'(out_vld), 128'(due));
      if (due) begin
        row_t r;
        r = sb.pop_front();
        check(tap_vld === r.mask, "R3", "tap valid mask", 128'(tap_vld), 128'(r.mask));
        for (int k = 0; k < STAGES; k++) begin
          if (r.mask[k]) begin
            check(tap_i[k*SW +: SW] === r.ei[k*SW +: SW], "R1", "tap I",
                  128'(tap_i[k*SW +: SW]), 128'(r.ei[k*SW +: SW]));
            check(tap_q[k*SW +: SW] === r.eq[k*SW +: SW], "R2", "tap Q",
                  128'(tap_q[k*SW +: SW]), 128'(r.eq[k*SW +: SW]));
          end
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_vld = 1'b0;
    sb.delete(); hist.delete();
    repeat (3) @(negedge clk);
    // R6: outputs cleared after reset edges
    check(out_vld === 1'b0, "R6", "row strobe in reset", 128'(out_vld), 128'(0));
    check(tap_vld === '0, "R6", "tap valid in reset", 128'(tap_vld), 128'(0));
    rst = 1'b0;
  endtask

  task automatic run_epoch(input int count, input int seed, input bit gaps);
    for (int n = 0; n < count; n++) begin
      send(16'(n * 613 + seed), 16'(seed - n * 37));
      if (gaps && (n % 5 == 3)) idle(1 + (n % 3));
      if (gaps && n == 150) idle(20);
    end
    idle(STAGES + 2);
    check(sb.size() == 0, "R4", "rows outstanding", 128'(sb.size()), 128'(0));
  endtask

  initial begin
    do_reset();
    // dense stream, no gaps
    run_epoch(STAGES*DEPTH + 40, 16'h1234, 1'b0);
    // R5: idle cycles only, no rows expected (monitor flags any row)
    idle(30);
    check(out_vld === 1'b0, "R5", "idle row strobe", 128'(out_vld), 128'(0));
    // R6: reset mid-run, then refill with gaps; old data must not appear
    do_reset();
    run_epoch(STAGES*DEPTH + 60, -16'sd20000, 1'b1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #600000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule